// File: doc/BRIEF.md
# Register Read-Modify-Write Execution Unit

This block runs one register instruction at a time for a small I/O sequencer. A 32-bit instruction word carries an operator code, an operand-select bit, a 7-bit register address and an 8-bit immediate. The unit reads the addressed byte from its internal register bank. It combines that byte with either the immediate or a dedicated byte scratch register, then writes the result back to the same register.

Instructions enter through a valid/word pair. They are accepted only while the unit is idle. Busy covers the three execution cycles, and done marks the writeback cycle. An illegal operator, or a subtract that selects the scratch operand, is refused with a one-cycle error pulse. Because subtract is refused in scratch mode, software negates a value with XOR 0xFF followed by add 1, and then adds.

A preload write port fills registers for test. A registered peek port reads any register back, including the scratch register, which sits at address `SCR_ADDR` (default 8).

Top module: `reg_rmw_unit`

## Requirements
- R1: The instruction fields are operator = word[26:24], operand select = word[23], register address = word[22:16] and immediate = word[15:8]. All 128 addresses are reachable, including 0x7F.
- R2: Operator 000 writes the second operand into the register. Operator 010 writes the OR, 100 writes the AND and 011 writes the XOR of the register and the second operand.
- R3: Operator 110 adds and operator 111 subtracts (register minus operand), both modulo 256. Adding 0xFF decrements the register and wraps from 0x00 to 0xFF.
- R4: With word[23]=1 the second operand is the scratch register (address `SCR_ADDR`) and the immediate is ignored. XOR 0xFF then add 1 on the scratch register yields its two's complement, and adding that to another register gives the difference.
- R5: Subtract (111) with word[23]=1 is refused. err goes high for exactly one cycle, busy stays low and no register changes.
- R6: Operator codes 001 and 101 are illegal and are refused in the same way as R5.
- R7: A legal instruction accepted at a clock edge raises busy for the next three cycles. done is high only in the third of those cycles. The new value is readable once busy falls.
- R8: instr_valid is ignored while busy is high. An instruction held or presented during execution has no effect.
- R9: A preload write takes effect only while busy is low and is dropped while busy is high. A preload and an instruction accepted in the same cycle are applied in that order, so the instruction reads the preloaded value.
- R10: peek_data shows the register selected by peek_addr one clock edge later.
- R11: When the target is the scratch register and word[23]=1, both operands are the scratch value from before the instruction.
- R12: After reset busy, done and err are low and the scratch register reads 0x00.
- R13: Instruction bits [31:27] and [7:0] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present |
| instr_word | input | 32 | Instruction word |
| busy | output | 1 | Instruction in execution |
| done | output | 1 | Writeback cycle marker |
| err | output | 1 | One-cycle refusal pulse |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 7 | Preload register address |
| pre_data | input | 8 | Preload data |
| peek_addr | input | 7 | Inspection read address |
| peek_data | output | 8 | Inspection read data, one cycle later |

## Verification
Two functions can land in the same cycle: a preload write and the acceptance of an instruction that targets the same register. The bench drives both in one cycle and expects the instruction to operate on the freshly preloaded byte. It also drives a preload and a second instruction while busy is high, and expects both to vanish. A behavioural model with its own memory array and cycle counter judges busy, done and err on every clock, and judges register contents through the peek port after each instruction.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  // Field positions inside the instruction word
  localparam int OPC_LSB  = 24;
  localparam int OPC_W    = 3;
  localparam int SEL_BIT  = 23;
  localparam int ADR_LSB  = 16;
  localparam int IMM_LSB  = 8;

  typedef enum logic [2:0] {
    OP_MOV = 3'b000,
    OP_OR  = 3'b010,
    OP_XOR = 3'b011,
    OP_AND = 3'b100,
    OP_ADD = 3'b110,
    OP_SUB = 3'b111
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_CMP  = 2'd2,
    ST_WR   = 2'd3
  } st_e;
endpackage

// File: rtl/rmw_decode.sv
module rmw_decode
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic [OPC_LSB+OPC_W-1:IMM_LSB] fields,
  output logic [OPC_W-1:0]               op,
  output logic                           sel,
  output logic [ADDR_W-1:0]              addr,
  output logic [DATA_W-1:0]              imm,
  output logic                           legal
);
  assign op   = fields[OPC_LSB +: OPC_W];
  assign sel  = fields[SEL_BIT];
  assign addr = fields[ADR_LSB +: ADDR_W];
  assign imm  = fields[IMM_LSB +: DATA_W];

  always_comb begin
    unique case (op)
      OP_MOV, OP_OR, OP_XOR, OP_AND, OP_ADD: legal = 1'b1;
      OP_SUB:                                legal = !sel;
      default:                               legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OPC_W-1:0]  op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    case (op)
      OP_MOV:  y = b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_AND:  y = a & b;
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/rmw_regbank.sv
module rmw_regbank #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int SCR_ADDR = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] xaddr,
  output logic [DATA_W-1:0] xdata,
  input  logic [ADDR_W-1:0] paddr,
  output logic [DATA_W-1:0] pdata,
  output logic [DATA_W-1:0] scratch
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] SCR = ADDR_W'(SCR_ADDR);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] xmem_q, pmem_q, pscr_q, scr_q;
  logic              xsel_q, psel_q;
  logic              scr_we;

  assign scr_we = we && (waddr == SCR);

  // Plain array with one write and two registered reads
  always_ff @(posedge clk) begin
    if (we && !scr_we) mem[waddr] <= wdata;
    xmem_q <= mem[xaddr];
    pmem_q <= mem[paddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scr_q  <= '0;
      pscr_q <= '0;
      xsel_q <= 1'b0;
      psel_q <= 1'b0;
    end else begin
      if (scr_we) scr_q <= wdata;
      pscr_q <= scr_q;
      xsel_q <= (xaddr == SCR);
      psel_q <= (paddr == SCR);
    end
  end

  assign xdata   = xsel_q ? scr_q  : xmem_q;
  assign pdata   = psel_q ? pscr_q : pmem_q;
  assign scratch = scr_q;

  AST_SCR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !scr_we |=> $stable(scr_q)); // R9
endmodule

// File: rtl/reg_rmw_unit.sv
module reg_rmw_unit
  import rmw_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int SCR_ADDR = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [31:0]       instr_word,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [DATA_W-1:0] pre_data,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [DATA_W-1:0] peek_data
);
  logic [OPC_W-1:0]  d_op;
  logic              d_sel, d_legal;
  logic [ADDR_W-1:0] d_addr;
  logic [DATA_W-1:0] d_imm;

  st_e               st_q;
  logic [OPC_W-1:0]  op_q;
  logic              sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] imm_q, opnd_q, res_q, alu_y, rd_val, scr_val;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              unused_bits;

  assign unused_bits = ^{instr_word[31:OPC_LSB+OPC_W], instr_word[IMM_LSB-1:0]};

  rmw_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .fields (instr_word[OPC_LSB+OPC_W-1:IMM_LSB]),
    .op     (d_op),
    .sel    (d_sel),
    .addr   (d_addr),
    .imm    (d_imm),
    .legal  (d_legal)
  );

  rmw_alu #(.DATA_W(DATA_W)) u_alu (
    .op (op_q),
    .a  (rd_val),
    .b  (opnd_q),
    .y  (alu_y)
  );

  // Writeback has the port in WR; preload only while idle
  always_comb begin
    if (st_q == ST_WR) begin
      wr_en   = 1'b1;
      wr_addr = addr_q;
      wr_data = res_q;
    end else begin
      wr_en   = pre_we && (st_q == ST_IDLE);
      wr_addr = pre_addr;
      wr_data = pre_data;
    end
  end

  rmw_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SCR_ADDR(SCR_ADDR)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en),
    .waddr   (wr_addr),
    .wdata   (wr_data),
    .xaddr   (addr_q),
    .xdata   (rd_val),
    .paddr   (peek_addr),
    .pdata   (peek_data),
    .scratch (scr_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      op_q   <= '0;
      sel_q  <= 1'b0;
      addr_q <= '0;
      imm_q  <= '0;
      opnd_q <= '0;
      res_q  <= '0;
    end else begin
      err  <= 1'b0;
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (instr_valid) begin
          if (d_legal) begin
            op_q   <= d_op;
            sel_q  <= d_sel;
            addr_q <= d_addr;
            imm_q  <= d_imm;
            busy   <= 1'b1;
            st_q   <= ST_RD;
          end else begin
            err <= 1'b1;
          end
        end
        ST_RD: begin
          opnd_q <= sel_q ? scr_val : imm_q;
          st_q   <= ST_CMP;
        end
        ST_CMP: begin
          res_q <= alu_y;
          done  <= 1'b1;
          st_q  <= ST_WR;
        end
        ST_WR: begin
          busy <= 1'b0;
          st_q <= ST_IDLE;
        end
      endcase
    end
  end

  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> busy); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy && !done); // R7
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy); // R5
  AST_ACCEPT_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(instr_valid)); // R8
endmodule

// File: tb/reg_rmw_unit_bench.sv
`timescale 1ns/1ps
module reg_rmw_unit_bench;
  localparam int SCR = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic       busy, done, err;
  logic       pre_we = 1'b0;
  logic [6:0] pre_addr = '0;
  logic [7:0] pre_data = '0;
  logic [6:0] peek_addr = '0;
  logic [7:0] peek_data;

  always #2 clk = ~clk;

  reg_rmw_unit u_reg_rmw_unit (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .busy(busy), .done(done), .err(err), .pre_we(pre_we), .pre_addr(pre_addr),
    .pre_data(pre_data), .peek_addr(peek_addr), .peek_data(peek_data)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Behavioural reference model
  int mem_m [128];
  int m_left = 0;
  bit m_err  = 1'b0;
  int p_op, p_sel, p_addr, p_imm;

  function automatic int calc(int op, int a, int b);
    case (op)
      0: return b;
      2: return a | b;
      3: return a ^ b;
      4: return a & b;
      6: return (a + b) & 255;
      7: return (a - b + 256) & 255;
      default: return a;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_left = 0;
      m_err = 1'b0;
      mem_m[SCR] = 0;
    end else begin
      m_err = 1'b0;
      if (m_left > 0) begin
        if (m_left == 1)
          mem_m[p_addr] = calc(p_op, mem_m[p_addr], (p_sel != 0) ? mem_m[SCR] : p_imm);
        m_left = m_left - 1;
      end else begin
        if (pre_we) mem_m[pre_addr] = pre_data;
        if (instr_valid) begin
          p_op   = int'(instr_word[26:24]);
          p_sel  = int'(instr_word[23]);
          p_addr = int'(instr_word[22:16]);
          p_imm  = int'(instr_word[15:8]);
          if (p_op == 1 || p_op == 5 || (p_op == 7 && p_sel == 1)) m_err = 1'b1;
          else m_left = 3;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Per-clock handshake comparison
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(busy == (m_left > 0), "R7 busy", int'(busy), int'(m_left > 0));
      chk(done == (m_left == 1), "R7 done", int'(done), int'(m_left == 1));
      chk(err == m_err, "R5/R6 err", int'(err), int'(m_err));
    end
  end

  function automatic logic [31:0] mk(input int op, input int sel, input int a,
                                     input int imm, input logic [12:0] junk);
    return {junk[12:8], 3'(op), 1'(sel), 7'(a), 8'(imm), junk[7:0]};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic preload(input int a, input int d);
    pre_we = 1'b1; pre_addr = 7'(a); pre_data = 8'(d);
    tick();
    pre_we = 1'b0;
  endtask

  task automatic issue(input logic [31:0] w);
    instr_valid = 1'b1; instr_word = w;
    tick();
    instr_valid = 1'b0;
    repeat (4) tick();
  endtask

  task automatic peek(input int a, input string tag);
    peek_addr = 7'(a);
    tick();
    chk(int'(peek_data) == mem_m[a], tag, int'(peek_data), mem_m[a]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R12 flags", int'({busy, done, err}), 0);
    peek(SCR, "R12 scratch");

    preload(1, 8'h11); preload(2, 8'h0F); preload(3, 8'h3C);
    preload(4, 8'hAA); preload(5, 8'h00); preload(6, 8'h10);
    preload(SCR, 8'h30); preload(9, 8'h50); preload(127, 8'h77);
    peek(3, "R10 peek"); peek(SCR, "R10 peek scratch");

    issue(mk(0, 0, 1, 8'h5A, 13'h0A5)); peek(1, "R2 move");
    issue(mk(2, 0, 2, 8'hF0, 13'h0A5)); peek(2, "R2 or");
    issue(mk(4, 0, 3, 8'h0F, 13'h0A5)); peek(3, "R2 and");
    issue(mk(3, 0, 4, 8'hFF, 13'h0A5)); peek(4, "R2 xor");
    issue(mk(6, 0, 5, 8'hFF, 13'h0A5)); peek(5, "R3 decrement wrap");
    issue(mk(6, 0, 5, 8'h01, 13'h0A5)); peek(5, "R3 increment wrap");
    issue(mk(7, 0, 6, 8'h20, 13'h0A5)); peek(6, "R3 subtract");
    issue(mk(0, 0, 127, 8'hC3, 13'h0A5)); peek(127, "R1 top address");
    issue(mk(6, 1, 1, 8'h99, 13'h0A5)); peek(1, "R4 scratch operand");

    issue(mk(7, 1, 2, 8'h01, 13'h0A5)); peek(2, "R5 refused sub");
    peek(SCR, "R5 scratch kept");
    issue(mk(1, 0, 3, 8'h01, 13'h0A5)); peek(3, "R6 code 001");
    issue(mk(5, 0, 4, 8'h01, 13'h0A5)); peek(4, "R6 code 101");

    // Two's complement of scratch, then difference
    issue(mk(3, 0, SCR, 8'hFF, 13'h0A5));
    issue(mk(6, 0, SCR, 8'h01, 13'h0A5)); peek(SCR, "R4 negation");
    issue(mk(6, 1, 9, 8'h00, 13'h0A5)); peek(9, "R4 difference");
    issue(mk(6, 1, SCR, 8'h00, 13'h0A5)); peek(SCR, "R11 self operand");

    // R8: held valid and a second word during execution
    instr_valid = 1'b1; instr_word = mk(6, 0, 6, 8'h01, 13'h0A5);
    tick();
    instr_word = mk(0, 0, 3, 8'hEE, 13'h0A5);
    tick(); tick();
    instr_valid = 1'b0;
    repeat (3) tick();
    peek(3, "R8 ignored while busy"); peek(6, "R8 first executed");

    // R9: preload dropped while busy; preload and accept in the same cycle
    instr_valid = 1'b1; instr_word = mk(6, 0, 10, 8'h02, 13'h0A5);
    pre_we = 1'b1; pre_addr = 7'd10; pre_data = 8'h40;
    tick();
    instr_valid = 1'b0; pre_addr = 7'd4; pre_data = 8'h5C;
    tick();
    pre_we = 1'b0;
    repeat (3) tick();
    peek(10, "R9 same-cycle preload"); peek(4, "R9 dropped preload");

    // R13: other filler in the unused bits
    issue(mk(6, 0, 2, 8'h03, 13'h1FFF)); peek(2, "R13 filler high");
    issue(mk(6, 0, 2, 8'h03, 13'h0000)); peek(2, "R13 filler low");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule